// File: doc/BRIEF.md
# Legacy DMA Channel Address Generator

This block is one programmable channel of an old-style expansion-bus DMA controller. Software programs it through a narrow 8-bit register port. A single byte-pointer flip-flop steers each 8-bit access to the low or the high half of the 16-bit start-address and transfer-count registers. A separate page register supplies the upper address bits. Software also sets the transfer direction and masks or unmasks the channel.

Once the channel is unmasked, every cycle with the device request high moves one unit. In that cycle the block drives a 24-bit memory address and either a memory-read or a memory-write strobe. It then advances the address and decrements the count. When the last unit moves, the block raises terminal count and masks itself.

The 16-bit address counter wraps inside its page and never carries into the page bits. The `WORD_MODE` parameter shifts the address left by one, so each unit covers two bytes and the page window becomes 128 KiB.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is masked (`masked`=1), the byte pointer selects the low byte, and the page, address and count registers read back as zero.
- R2: Every read or write with `cfg_sel`=0 (address) or `cfg_sel`=1 (count) uses the low byte when the byte pointer is clear and the high byte when it is set, and then toggles the pointer. A write with `cfg_sel`=5 clears the pointer. Other selects leave the pointer unchanged.
- R3: In byte mode, `mem_addr` equals {page[7:0], address[15:0]} during a transfer. The page is written with `cfg_sel`=2.
- R4: The address counter wraps from 0xFFFF to 0x0000 and the page bits stay unchanged.
- R5: In word mode, `mem_addr` equals {page[7:1], address[15:0], 1'b0}, so the memory address advances by two per unit and bit 0 is always zero.
- R6: A write with `cfg_sel`=3 sets the direction from data bit 0. A value of 1 means memory-to-device, and a transfer then raises `mem_rd`. A value of 0 means device-to-memory, and a transfer then raises `mem_wr`. The two strobes are never high together.
- R7: While the channel is masked, `dreq` has no effect: no strobe, no terminal count, and address and count are unchanged. A write with `cfg_sel`=4 masks the channel when data bit 0 is 1 and unmasks it when bit 0 is 0.
- R8: The count holds the number of transfers minus one. Each transfer decrements it, wrapping from 0 to 0xFFFF. `tc` is high during the transfer made while the count is zero, and the channel is masked from the next cycle.
- R9: At any time, a read with `cfg_sel`=0 or 1 returns the current address or residue byte chosen by the pointer. `cfg_sel`=2 returns the page, and any other select returns {6'b0, masked, direction}.
- R10: A register write that falls in the same cycle as a transfer takes priority for that register: the written byte replaces its half and the step is dropped. A mask write in a terminal-count cycle loses: the channel ends up masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (advances byte pointer) |
| cfg_sel | input | 3 | Register select: 0 address, 1 count, 2 page, 3 direction, 4 mask, 5 pointer clear |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for the current select |
| dreq | input | 1 | Device request, one unit per cycle while high |
| mem_addr | output | 24 | Memory address of the current unit |
| mem_rd | output | 1 | Memory-to-device transfer strobe |
| mem_wr | output | 1 | Device-to-memory transfer strobe |
| tc | output | 1 | Terminal count, high during the last unit |
| masked | output | 1 | Channel mask state |

## Verification
Two functions can land in the same clock edge. A software write to the address or count can coincide with a transfer that steps the same register. A mask write can coincide with the terminal-count auto-mask. The bench provokes both by holding `dreq` high during the register write. It judges the result by comparing the strobes, the address of the following unit and the read-back residue against a behavioural model that applies the write-wins and mask-on-terminal-count rules. Byte-mode and word-mode instances run the same stimulus.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic [2:0] {
      SEL_ADDR   = 3'd0,
      SEL_COUNT  = 3'd1,
      SEL_PAGE   = 3'd2,
      SEL_DIR    = 3'd3,
      SEL_MASK   = 3'd4,
      SEL_PTRCLR = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   input  logic clear,
   output logic hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi <= 1'b0;
      else if (clear)  hi <= 1'b0;
      else if (access) hi <= ~hi;
   end

   p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      access && !clear |=> hi != $past(hi));
   p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !hi);
endmodule

// File: rtl/dma_step_ctr.sv
module dma_step_ctr #(
   parameter int DATA_W = 8,
   parameter bit UP     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_lo,
   input  logic                  ld_hi,
   input  logic [DATA_W-1:0]     ld_byte,
   input  logic                  step,
   output logic [2*DATA_W-1:0]   q
);
   localparam int W = 2 * DATA_W;

   logic [W-1:0] q_step;

   generate
      if (UP) begin : g_up
         assign q_step = q + W'(1);
      end else begin : g_down
         assign q_step = q - W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (ld_lo) q <= {q[W-1:DATA_W], ld_byte};
      else if (ld_hi) q <= {ld_byte, q[DATA_W-1:0]};
      else if (step)  q <= q_step;
   end

   p_step_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step && !ld_lo && !ld_hi |=> q == (UP ? $past(q) + W'(1) : $past(q) - W'(1)));
   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> q[DATA_W-1:0] == $past(ld_byte));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
   import dma_chan_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 8,
   parameter bit WORD_MODE = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic                          cfg_re,
   input  logic [2:0]                    cfg_sel,
   input  logic [DATA_W-1:0]             cfg_wdata,
   output logic [DATA_W-1:0]             cfg_rdata,
   input  logic                          dreq,
   output logic [PAGE_W+2*DATA_W-1:0]    mem_addr,
   output logic                          mem_rd,
   output logic                          mem_wr,
   output logic                          tc,
   output logic                          masked
);
   localparam int CNT_W  = 2 * DATA_W;
   localparam int MEM_AW = PAGE_W + CNT_W;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("dma_chan: DATA_W must be at least 2");
      end
      if (PAGE_W < 2) begin : g_bad_page
         $error("dma_chan: PAGE_W must be at least 2");
      end
   endgenerate

   reg_sel_e            sel;
   logic                ptr_hi;
   logic                dir_m2d;
   logic [PAGE_W-1:0]   page;
   logic [CNT_W-1:0]    cur_addr;
   logic [CNT_W-1:0]    residue;
   logic                xfer;
   logic                sel_addr, sel_cnt;
   logic                ptr_access, ptr_clear;

   assign sel        = reg_sel_e'(cfg_sel);
   assign sel_addr   = (sel == SEL_ADDR);
   assign sel_cnt    = (sel == SEL_COUNT);
   assign ptr_access = (cfg_we || cfg_re) && (sel_addr || sel_cnt);
   assign ptr_clear  = cfg_we && (sel == SEL_PTRCLR);

   assign xfer   = dreq && !masked;
   assign tc     = xfer && (residue == '0);
   assign mem_rd = xfer && dir_m2d;
   assign mem_wr = xfer && !dir_m2d;

   dma_byte_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (ptr_access),
      .clear  (ptr_clear),
      .hi     (ptr_hi)
   );

   dma_step_ctr #(.DATA_W(DATA_W), .UP(1'b1)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (cfg_we && sel_addr && !ptr_hi),
      .ld_hi   (cfg_we && sel_addr && ptr_hi),
      .ld_byte (cfg_wdata),
      .step    (xfer),
      .q       (cur_addr)
   );

   dma_step_ctr #(.DATA_W(DATA_W), .UP(1'b0)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (cfg_we && sel_cnt && !ptr_hi),
      .ld_hi   (cfg_we && sel_cnt && ptr_hi),
      .ld_byte (cfg_wdata),
      .step    (xfer),
      .q       (residue)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page    <= '0;
         dir_m2d <= 1'b0;
         masked  <= 1'b1;
      end else begin
         if (cfg_we && sel == SEL_PAGE) page    <= PAGE_W'(cfg_wdata);
         if (cfg_we && sel == SEL_DIR)  dir_m2d <= cfg_wdata[0];
         if (tc)                        masked  <= 1'b1;
         else if (cfg_we && sel == SEL_MASK) masked <= cfg_wdata[0];
      end
   end

   generate
      if (WORD_MODE) begin : g_word
         assign mem_addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
      end else begin : g_byte
         assign mem_addr = {page, cur_addr};
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_ADDR:  cfg_rdata = ptr_hi ? cur_addr[CNT_W-1:DATA_W] : cur_addr[DATA_W-1:0];
         SEL_COUNT: cfg_rdata = ptr_hi ? residue[CNT_W-1:DATA_W]  : residue[DATA_W-1:0];
         SEL_PAGE:  cfg_rdata = DATA_W'(page);
         default:   cfg_rdata = DATA_W'({masked, dir_m2d});
      endcase
   end

   p_tc_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> masked);
   p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && sel == SEL_PAGE) |=> $stable(page));
   p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      masked && !(cfg_we && (sel_addr || sel_cnt)) |=> $stable(residue) && $stable(cur_addr));
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   p_addr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(xfer) && !$past(cfg_we && sel_addr) && $stable(page) |->
         mem_addr[MEM_AW-PAGE_W-1:0] != $past(mem_addr[MEM_AW-PAGE_W-1:0]));
endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/100ps
module dma_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_re = 1'b0, dreq = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic [7:0]  rdata_b, rdata_w;
   logic [23:0] addr_b, addr_w;
   logic        rd_b, wr_b, tc_b, msk_b, rd_w, wr_w, tc_w, msk_w;

   int vectors = 0;
   int miscompares = 0;

   int m_page, m_addr, m_cnt, m_mask, m_dir, m_ptr;

   always #2 clk = ~clk;

   dma_chan #(.WORD_MODE(1'b0)) u_dma_chan (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .dreq(dreq), .mem_addr(addr_b),
      .mem_rd(rd_b), .mem_wr(wr_b), .tc(tc_b), .masked(msk_b));

   dma_chan #(.WORD_MODE(1'b1)) u_dma_chan_word (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_w), .dreq(dreq), .mem_addr(addr_w),
      .mem_rd(rd_w), .mem_wr(wr_w), .tc(tc_w), .masked(msk_w));

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_page = 0; m_addr = 0; m_cnt = 0; m_mask = 1; m_dir = 0; m_ptr = 0;
   endtask

   task automatic compare_all(input string tag);
      int xf, etc, rd_exp, ab, aw;
      xf  = (dreq && m_mask == 0) ? 1 : 0;
      etc = (xf == 1 && m_cnt == 0) ? 1 : 0;
      ab  = (m_page << 16) | m_addr;
      aw  = ((m_page >> 1) << 17) | (m_addr << 1);
      case (cfg_sel)
         3'd0: rd_exp = m_ptr ? (m_addr >> 8) & 255 : m_addr & 255;
         3'd1: rd_exp = m_ptr ? (m_cnt >> 8) & 255 : m_cnt & 255;
         3'd2: rd_exp = m_page;
         default: rd_exp = (m_mask << 1) | m_dir;
      endcase
      chk(tag, "byte mem_addr", 32'(addr_b), 32'(ab));
      chk(tag, "word mem_addr", 32'(addr_w), 32'(aw));
      chk(tag, "mem_rd", {31'd0, rd_b}, 32'(xf & m_dir));
      chk(tag, "mem_wr", {31'd0, wr_b}, 32'(xf & (1 - m_dir)));
      chk(tag, "tc", {31'd0, tc_b}, 32'(etc));
      chk(tag, "masked", {31'd0, msk_b}, 32'(m_mask));
      chk(tag, "rdata", 32'(rdata_b), 32'(rd_exp));
      chk(tag, "word strobes", {29'd0, rd_w, wr_w, tc_w}, {29'd0, rd_b, wr_b, tc_b});
      chk(tag, "word rdata/mask", {23'd0, msk_w, rdata_w}, {23'd0, msk_b, rdata_b});
   endtask

   task automatic model_update(input bit we, input bit re, input int sel, input int d, input bit rq);
      int xf, etc;
      xf  = (rq && m_mask == 0) ? 1 : 0;
      etc = (xf == 1 && m_cnt == 0) ? 1 : 0;
      if (we && sel == 0)
         m_addr = m_ptr ? ((d << 8) | (m_addr & 255)) : ((m_addr & 16'hFF00) | d);
      else if (xf == 1)
         m_addr = (m_addr + 1) & 16'hFFFF;
      if (we && sel == 1)
         m_cnt = m_ptr ? ((d << 8) | (m_cnt & 255)) : ((m_cnt & 16'hFF00) | d);
      else if (xf == 1)
         m_cnt = (m_cnt + 16'hFFFF) & 16'hFFFF;
      if (etc == 1) m_mask = 1;
      else if (we && sel == 4) m_mask = d & 1;
      if (we && sel == 3) m_dir = d & 1;
      if (we && sel == 2) m_page = d;
      if (we && sel == 5) m_ptr = 0;
      else if ((we || re) && (sel == 0 || sel == 1)) m_ptr = 1 - m_ptr;
   endtask

   task automatic step(input bit we, input bit re, input int sel, input int d, input bit rq, input string tag);
      @(negedge clk);
      cfg_we = we; cfg_re = re; cfg_sel = 3'(sel); cfg_wdata = 8'(d); dreq = rq;
      #1;
      compare_all(tag);
      @(posedge clk);
      model_update(we, re, sel, d, rq);
   endtask

   task automatic wr(input int sel, input int d, input string tag);
      step(1'b1, 1'b0, sel, d, 1'b0, tag);
   endtask

   task automatic rd(input int sel, input string tag);
      step(1'b0, 1'b1, sel, 0, 1'b0, tag);
   endtask

   task automatic req(input string tag);
      step(1'b0, 1'b0, 4, 0, 1'b1, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, read back every register, requests ignored
      rd(0, "R1"); rd(0, "R1"); rd(1, "R1"); rd(1, "R1");
      rd(2, "R1"); rd(4, "R1"); req("R1 R7");
      // R2: pointer alternation and clear
      wr(5, 0, "R2");
      wr(0, 8'hFE, "R2"); wr(0, 8'hFF, "R2");
      rd(0, "R2"); wr(5, 0, "R2"); rd(0, "R2"); rd(0, "R2");
      rd(3, "R2"); wr(5, 0, "R2");
      // R3 R6: program page, count, direction, unmask
      wr(2, 8'h13, "R3"); wr(1, 8'h03, "R8"); wr(1, 8'h00, "R8");
      wr(3, 1, "R6"); wr(4, 0, "R7");
      // R4 R5 R8: four transfers across the wrap, then auto-mask
      req("R4"); req("R4"); req("R4 R5"); req("R8");
      req("R7"); req("R7");
      // R9: residue and address readback
      rd(1, "R9"); rd(1, "R9"); rd(0, "R9"); rd(0, "R9"); rd(2, "R9");
      // R6: other direction, gaps in requests
      wr(3, 0, "R6"); wr(5, 0, "R2");
      wr(0, 8'h10, "R5"); wr(0, 8'h00, "R5");
      wr(1, 8'h05, "R8"); wr(1, 8'h00, "R8");
      wr(4, 0, "R7"); wr(2, 8'hA6, "R3");
      req("R6"); step(0, 0, 4, 0, 0, "R6"); req("R5 R6");
      // R10: register write in a transfer cycle
      step(1, 0, 0, 8'h40, 1, "R10");
      req("R10"); step(1, 0, 0, 8'h02, 1, "R10"); req("R10");
      step(1, 0, 1, 8'h00, 1, "R10"); req("R10");
      rd(1, "R9"); rd(1, "R9");
      // R10: mask write coincides with terminal count
      wr(5, 0, "R2"); wr(1, 0, "R8"); wr(1, 0, "R8");
      wr(4, 0, "R7");
      step(1, 0, 4, 0, 1, "R10");
      req("R7"); rd(4, "R10");
      rd(1, "R8"); rd(1, "R8"); rd(0, "R9"); rd(0, "R9");
      // R7: mask by software mid-transfer
      wr(4, 0, "R7"); req("R7"); wr(4, 1, "R7"); req("R7"); req("R7");
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule